// File: doc/BRIEF.md
# Floating-Point Exception Queue

This block tracks floating-point operations that have been launched but have not yet finished. Each launch stores the instruction word together with its address in a small in-order queue. A normal completion retires the oldest entry. When the oldest operation reports a fault, the queue locks. The faulting pair stays at the head so that trap software can read it, and an exception-pending flag goes high.

While the queue is locked, the trap handler takes entries out one at a time with a read pulse, starting at the head. The pending flag drops once the last entry has been taken. The block also drives a stall request to the host pipeline. The request is raised while the queue is full, so a further launch cannot overflow it, and while a trap is pending. The empty output serves as the queue-status bit that a status/control register shows.

Top module: `fp_exc_queue`

## Requirements
- R1: After reset, empty_o=1, full_o=0, exc_o=0 and stall_o=0.
- R2: A launch that is accepted stores its instruction/address pair at the tail. If the queue was empty, the pair appears on head_insn_o/head_addr_o in the cycle after the launch.
- R3: A completion retires the head entry, so entries leave in launch order. A completion while the queue is empty has no effect.
- R4: A launch and a completion in the same cycle, in normal mode with a queue that is neither empty nor full, leave the occupancy unchanged and advance the head.
- R5: full_o=1 when DEPTH entries (default 4) are held. stall_o=1 while full, and a launch is then refused even when a completion arrives in the same cycle. That completion still retires the head.
- R6: A fault with a non-empty queue in normal mode sets exc_o in the next cycle and keeps the head pair unchanged. A launch or completion in that same cycle is ignored. A fault while the queue is empty is ignored.
- R7: While exc_o=1, stall_o=1, and launches and completions have no effect on occupancy or head.
- R8: While exc_o=1, each trap-read pulse removes one entry, head first. exc_o clears in the cycle after the last entry is removed. A trap-read pulse while exc_o=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Start an operation (enqueue request) |
| launch_insn_i | input | INSN_W | Instruction word of the launched operation |
| launch_addr_i | input | ADDR_W | Address of the launched operation |
| done_i | input | 1 | Head operation completed without fault |
| fault_i | input | 1 | Head operation raised an exception |
| trap_pop_i | input | 1 | Trap software reads out and removes the head entry |
| head_insn_o | output | INSN_W | Instruction word at the head |
| head_addr_o | output | ADDR_W | Address at the head |
| empty_o | output | 1 | Queue holds no entries (queue-status bit) |
| full_o | output | 1 | Queue holds DEPTH entries |
| exc_o | output | 1 | Exception pending, queue locked |
| stall_o | output | 1 | Freeze request to the host pipeline |

## Verification
The hardest state to reach is a fault that lands on a full queue while a launch and a completion arrive in the same cycle, followed by a drain in which the stray launches and completions must all be ignored. The random stimulus favours launches so that the queue stays near full. It injects faults at a low rate and raises trap-read pulses only about half the time, so that locked periods last several cycles. Directed sequences first force each edge case once: a fault into an empty queue, a full queue with a completion, and a trap read outside a trap.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  typedef enum logic {
    FPQ_RUN  = 1'b0,
    FPQ_TRAP = 1'b1
  } fpq_mode_e;
endpackage

// File: rtl/fpq_ring.sv
module fpq_ring #(
  parameter int DEPTH  = 4,
  parameter int INSN_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [INSN_W-1:0] head_insn_o,
  output logic [ADDR_W-1:0] head_addr_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [INSN_W-1:0] insn_mem [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop_i)  rd_ptr <= bump(rd_ptr);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        insn_mem[g] <= '0;
        addr_mem[g] <= '0;
      end else if (push_i && wr_ptr == PTR_W'(g)) begin
        insn_mem[g] <= insn_i;
        addr_mem[g] <= addr_i;
      end
    end
  end

  assign head_insn_o = insn_mem[rd_ptr];
  assign head_addr_o = addr_mem[rd_ptr];
endmodule

// File: rtl/fpq_ctrl.sv
module fpq_ctrl
  import fpq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             done_i,
  input  logic             fault_i,
  input  logic             trap_pop_i,
  output logic             push_o,
  output logic             pop_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             exc_o,
  output logic             stall_o
);
  fpq_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             take_fault;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign exc_o   = (mode_q == FPQ_TRAP);
  // freeze host before an incoming launch could overflow, and during a trap
  assign stall_o = exc_o | full_o;

  always_comb begin
    take_fault = 1'b0;
    push_o     = 1'b0;
    pop_o      = 1'b0;
    mode_d     = mode_q;
    if (mode_q == FPQ_RUN) begin
      take_fault = fault_i & ~empty_o;
      push_o     = launch_i & ~stall_o & ~take_fault;
      pop_o      = done_i & ~empty_o & ~take_fault;
      if (take_fault) mode_d = FPQ_TRAP;
    end else begin
      pop_o = trap_pop_i & ~empty_o;
      if (pop_o && cnt_q == CNT_W'(1)) mode_d = FPQ_RUN;
    end
    cnt_d = cnt_q + CNT_W'(push_o) - CNT_W'(pop_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= FPQ_RUN;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fp_exc_queue.sv
module fp_exc_queue #(
  parameter int DEPTH  = 4,
  parameter int INSN_W = 32,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [INSN_W-1:0] launch_insn_i,
  input  logic [ADDR_W-1:0] launch_addr_i,
  input  logic              done_i,
  input  logic              fault_i,
  input  logic              trap_pop_i,
  output logic [INSN_W-1:0] head_insn_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              exc_o,
  output logic              stall_o
);
  logic             push, pop;
  logic [CNT_W-1:0] cnt;

  fpq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch_i),
    .done_i     (done_i),
    .fault_i    (fault_i),
    .trap_pop_i (trap_pop_i),
    .push_o     (push),
    .pop_o      (pop),
    .cnt_o      (cnt),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .exc_o      (exc_o),
    .stall_o    (stall_o)
  );

  fpq_ring #(.DEPTH(DEPTH), .INSN_W(INSN_W), .ADDR_W(ADDR_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .insn_i      (launch_insn_i),
    .addr_i      (launch_addr_i),
    .head_insn_o (head_insn_o),
    .head_addr_o (head_addr_o)
  );
endmodule

// File: rtl/fpq_chk.sv
module fpq_chk #(
  parameter int DEPTH  = 4,
  parameter int INSN_W = 32,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              launch_i,
  input logic              done_i,
  input logic              fault_i,
  input logic              trap_pop_i,
  input logic [INSN_W-1:0] head_insn_o,
  input logic [ADDR_W-1:0] head_addr_o,
  input logic              empty_o,
  input logic              full_o,
  input logic              exc_o,
  input logic              stall_o,
  input logic [CNT_W-1:0]  cnt
);
  a_r3_empty_done_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !launch_i) |=> empty_o);

  a_r4_launch_done_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_o && launch_i && done_i && !fault_i && !empty_o && !full_o) |=> $stable(cnt));

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !done_i && !trap_pop_i) |=> full_o);

  a_r5_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));

  a_r6_fault_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_o && fault_i && !empty_o) |=> (exc_o && $stable(head_insn_o) && $stable(head_addr_o)));

  a_r7_trap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o && !trap_pop_i) |=> (exc_o && $stable(cnt) && $stable(head_insn_o) && $stable(head_addr_o)));

  a_r7_trap_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (stall_o && !empty_o));

  a_r8_clear_on_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(exc_o) |-> empty_o);
endmodule

bind fp_exc_queue fpq_chk #(.DEPTH(DEPTH), .INSN_W(INSN_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_fp_exc_queue.sv
module sim_fp_exc_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        launch_i = 1'b0, done_i = 1'b0, fault_i = 1'b0, trap_pop_i = 1'b0;
  logic [31:0] launch_insn_i = '0, launch_addr_i = '0;
  logic [31:0] head_insn_o, head_addr_o;
  logic        empty_o, full_o, exc_o, stall_o;

  int n_run = 0, n_fail = 0;
  logic [63:0] mq[$];
  bit m_exc = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fp_exc_queue #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "empty", 64'(empty_o), 64'(mq.size() == 0));
    chk(tag, "full", 64'(full_o), 64'(mq.size() == DEPTH));
    chk(tag, "exc", 64'(exc_o), 64'(m_exc));
    chk(tag, "stall", 64'(stall_o), 64'(m_exc || mq.size() == DEPTH));
    if (mq.size() > 0) chk(tag, "head", {head_insn_o, head_addr_o}, mq[0]);
  endtask

  task automatic model(input bit l, input logic [63:0] pair, input bit d, input bit f, input bit p);
    if (!m_exc) begin
      if (f && mq.size() > 0) m_exc = 1'b1;
      else begin
        bit was_full;
        was_full = (mq.size() == DEPTH);
        if (d && mq.size() > 0) void'(mq.pop_front());
        if (l && !was_full) mq.push_back(pair);
      end
    end else if (p && mq.size() > 0) begin
      void'(mq.pop_front());
      if (mq.size() == 0) m_exc = 1'b0;
    end
  endtask

  task automatic step(input bit l, input bit d, input bit f, input bit p, input string tag);
    logic [31:0] ins, ad;
    ins = $urandom; ad = $urandom;
    launch_i = l; done_i = d; fault_i = f; trap_pop_i = p;
    launch_insn_i = ins; launch_addr_i = ad;
    model(l, {ins, ad}, d, f, p);
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("R1");

    step(0, 1, 0, 0, "R3");            // completion on empty ignored
    step(0, 0, 0, 1, "R8");            // trap read outside trap ignored
    step(0, 0, 1, 0, "R6");            // fault on empty ignored
    step(1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R3");
    step(1, 1, 0, 0, "R4");
    step(1, 0, 0, 0, "R5");
    step(1, 0, 0, 0, "R5");            // now full
    step(1, 0, 0, 0, "R5");            // refused
    step(1, 1, 0, 0, "R5");            // completion retires, launch refused
    step(1, 0, 0, 0, "R5");
    step(1, 1, 1, 0, "R6");            // fault wins
    step(1, 1, 0, 0, "R7");
    step(1, 0, 0, 0, "R7");
    for (int i = 0; i < DEPTH + 1; i++) step(1, 1, 0, 1, "R8");
    step(0, 0, 0, 1, "R8");

    for (int i = 0; i < 4000; i++) begin
      bit l, d, f, p;
      l = ($urandom % 100) < 60;
      d = ($urandom % 100) < 35;
      f = ($urandom % 100) < 4;
      p = ($urandom % 100) < 50;
      step(l, d, f, p, m_exc ? "R8" : "R3");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule